// File: doc/BRIEF.md
# Idle Pad Power-Down Request Gate

This block sits on the address channels between an AXI master and a memory controller. It watches for bus activity, meaning a valid read or write request or any transaction still in flight. While the bus is quiet it counts slow microsecond ticks. When the programmed idle time has gone by, it raises an active-high pad power-down output and stalls both address channels.

A new request that arrives while the pads are asleep drops the power-down output in the next cycle, so the pads start waking at once. The request is held for a programmed number of fast bus-clock cycles before it is allowed through. During that time the master sees ready low, so its request stays where it is and is later forwarded unchanged.

A single enable turns the feature on or off. With the enable low the block behaves as plain wires. In-flight transactions are counted from the downstream address handshakes and from completion strobes (the last read beat, or the write response). The block never powers down while any transaction is outstanding.

Top module: `pad_sleep_gate`

## Requirements
- R1: After reset the pad power-down output is low and both address channels pass through.
- R2: When the pads are neither asleep nor waking, dn_arvalid equals up_arvalid, up_arready equals dn_arready, and the write address pair behaves the same way.
- R3: With the enable high and no activity, the pad power-down output rises in the cycle after the N-th idle tick, where N is idle_limit. No earlier tick raises it.
- R4: Activity in any cycle clears the idle count. A request present in the same cycle as the would-be N-th tick prevents power-down, and a full N further idle ticks are then needed.
- R5: With the enable low the pad power-down output never rises, whatever the ticks.
- R6: While the pads are asleep or waking, dn_arvalid, dn_awvalid, up_arready and up_awready are all low.
- R7: A read or write request seen while asleep lowers the pad power-down output in the next cycle.
- R8: The first address handshake after a wake-up occurs exactly W cycles after the first cycle with the power-down output low, where W is wake_limit. No handshake occurs earlier.
- R9: While the outstanding-transaction count (address handshakes minus completions) is nonzero, the pad power-down output stays low.
- R10: An idle_limit of zero behaves as one tick, and a wake_limit of zero behaves as one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| us_tick | input | 1 | One-cycle strobe every microsecond, synchronous to clk |
| sleep_en | input | 1 | Enables idle power-down |
| idle_limit | input | 9 | Idle time before power-down, in ticks |
| wake_limit | input | 5 | Wake-up hold time, in clk cycles |
| up_arvalid | input | 1 | Read address valid from master |
| up_arready | output | 1 | Read address ready to master |
| dn_arvalid | output | 1 | Read address valid to controller |
| dn_arready | input | 1 | Read address ready from controller |
| up_awvalid | input | 1 | Write address valid from master |
| up_awready | output | 1 | Write address ready to master |
| dn_awvalid | output | 1 | Write address valid to controller |
| dn_awready | input | 1 | Write address ready from controller |
| rd_done | input | 1 | Last read beat accepted (one strobe per read) |
| wr_done | input | 1 | Write response accepted (one strobe per write) |
| pad_pd | output | 1 | Pad power-down, active high |

## Verification
The bench sweeps a grid of idle and wake settings that includes zero and the largest wake value. For each setting it counts ticks up to the threshold, then wakes the block once through the read channel and once through the write channel, and measures the exact distance from the power-down fall to the first handshake. A request that lands on the threshold tick tells a cleared count apart from one that was merely paused, because power-down must then need a full new run of ticks. Ticks given while a read is outstanding, and ticks given with the enable low, tell apart the two ways power-down can be prevented.

// File: rtl/pg_pkg.sv
package pg_pkg;
  typedef enum logic [1:0] {
    PG_IDLE   = 2'd0,
    PG_ACTIVE = 2'd1,
    PG_STOP   = 2'd2,
    PG_RESUME = 2'd3
  } pg_state_e;

  // a programmed limit of zero counts as one
  function automatic logic [15:0] at_least_one(input logic [15:0] v);
    return (v == 16'd0) ? 16'd1 : v;
  endfunction
endpackage

// File: rtl/pg_txn_tracker.sv
module pg_txn_tracker #(
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ar_hs,
  input  logic          aw_hs,
  input  logic          r_done,
  input  logic          b_done,
  output logic          busy,
  output logic [CW-1:0] count
);
  localparam int NW = CW + 1;

  logic [NW-1:0] nxt;

  always_comb begin
    nxt = {1'b0, count} + NW'(ar_hs) + NW'(aw_hs) - NW'(r_done) - NW'(b_done);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) count <= '0;
    else        count <= nxt[CW-1:0];
  end

  assign busy = (count != '0);

  // R9
  no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (count == '0) |-> !(r_done || b_done) || ar_hs || aw_hs);
endmodule

// File: rtl/pg_idle_timer.sv
module pg_idle_timer #(
  parameter int IW = 9
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  logic          tick,
  input  logic [IW-1:0] limit,
  output logic          expire
);
  import pg_pkg::*;

  logic [IW-1:0] cnt;
  logic [15:0]   eff;
  logic [15:0]   cnt_inc;

  assign eff     = at_least_one(16'(limit));
  assign cnt_inc = 16'(cnt) + 16'd1;
  assign expire  = tick && !clear && (cnt_inc >= eff);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt <= '0;
    else if (clear)        cnt <= '0;
    else if (tick) begin
      if (expire)          cnt <= '0;
      else                 cnt <= cnt + 1'b1;
    end
  end

  // R3
  idle_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    16'(cnt) < eff);
endmodule

// File: rtl/pg_wake_timer.sv
module pg_wake_timer #(
  parameter int WW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic [WW-1:0] limit,
  output logic          done
);
  import pg_pkg::*;

  logic [WW-1:0] cnt;
  logic [15:0]   eff;

  assign eff  = at_least_one(16'(limit));
  assign done = run && ((16'(cnt) + 16'd1) >= eff);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   cnt <= '0;
    else if (!run) cnt <= '0;
    else          cnt <= cnt + 1'b1;
  end

  // R8
  wake_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(run) |-> (cnt == '0));
endmodule

// File: rtl/pad_sleep_gate.sv
module pad_sleep_gate #(
  parameter int IW = 9,
  parameter int WW = 5,
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          us_tick,
  input  logic          sleep_en,
  input  logic [IW-1:0] idle_limit,
  input  logic [WW-1:0] wake_limit,
  input  logic          up_arvalid,
  output logic          up_arready,
  output logic          dn_arvalid,
  input  logic          dn_arready,
  input  logic          up_awvalid,
  output logic          up_awready,
  output logic          dn_awvalid,
  input  logic          dn_awready,
  input  logic          rd_done,
  input  logic          wr_done,
  output logic          pad_pd
);
  import pg_pkg::*;

  localparam int GW = WW + 1;

  pg_state_e     state, state_nxt;
  logic          pass;
  logic          req_seen;
  logic          activity;
  logic          busy;
  logic [CW-1:0] txn_count;
  logic          ar_hs, aw_hs;
  logic          idle_clear;
  logic          idle_expire;
  logic          wake_done;

  assign pass       = (state == PG_IDLE) || (state == PG_ACTIVE);
  assign dn_arvalid = up_arvalid && pass;
  assign dn_awvalid = up_awvalid && pass;
  assign up_arready = dn_arready && pass;
  assign up_awready = dn_awready && pass;
  assign ar_hs      = dn_arvalid && dn_arready;
  assign aw_hs      = dn_awvalid && dn_awready;
  assign req_seen   = up_arvalid || up_awvalid;
  assign activity   = req_seen || busy;
  assign idle_clear = !sleep_en || (state != PG_IDLE) || activity;
  assign pad_pd     = (state == PG_STOP);

  pg_txn_tracker #(.CW(CW)) u_txn (
    .clk(clk), .rst_n(rst_n), .ar_hs(ar_hs), .aw_hs(aw_hs),
    .r_done(rd_done), .b_done(wr_done), .busy(busy), .count(txn_count)
  );

  pg_idle_timer #(.IW(IW)) u_idle (
    .clk(clk), .rst_n(rst_n), .clear(idle_clear), .tick(us_tick),
    .limit(idle_limit), .expire(idle_expire)
  );

  pg_wake_timer #(.WW(WW)) u_wake (
    .clk(clk), .rst_n(rst_n), .run(state == PG_RESUME),
    .limit(wake_limit), .done(wake_done)
  );

  always_comb begin
    state_nxt = state;
    unique case (state)
      PG_IDLE:   if (activity)                 state_nxt = PG_ACTIVE;
                 else if (idle_expire)         state_nxt = PG_STOP;
      PG_ACTIVE: if (!activity)                state_nxt = PG_IDLE;
      PG_STOP:   if (req_seen || !sleep_en)    state_nxt = PG_RESUME;
      PG_RESUME: if (wake_done)                state_nxt = PG_ACTIVE;
      default:                                 state_nxt = PG_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= PG_IDLE;
    else        state <= state_nxt;
  end

  // checker state: cycles since pad_pd was last high, saturating
  logic [GW-1:0] gap_cnt;
  logic [15:0]   wake_eff;
  assign wake_eff = at_least_one(16'(wake_limit));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 gap_cnt <= '1;
    else if (pad_pd)            gap_cnt <= '0;
    else if (gap_cnt != '1)     gap_cnt <= gap_cnt + 1'b1;
  end

  // R6
  sleep_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pad_pd |-> !(up_arready || up_awready || dn_arvalid || dn_awvalid));

  // R8
  wake_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((up_arvalid && up_arready) || (up_awvalid && up_awready)) |-> (16'(gap_cnt) >= wake_eff));

  // R3
  stop_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pad_pd) |-> $past(us_tick && sleep_en && !up_arvalid && !up_awvalid));

  // R7
  wake_prompt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pad_pd && (up_arvalid || up_awvalid)) |=> !pad_pd);

  // R9
  busy_awake_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (txn_count != '0) |-> !pad_pd);
endmodule

// File: tb/sim_pad_sleep_gate.sv
`timescale 1ns/1ps
module sim_pad_sleep_gate;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       us_tick = 1'b0;
  logic       sleep_en = 1'b0;
  logic [8:0] idle_limit = '0;
  logic [4:0] wake_limit = '0;
  logic       up_arvalid = 1'b0, dn_arready = 1'b0;
  logic       up_awvalid = 1'b0, dn_awready = 1'b0;
  logic       rd_done = 1'b0, wr_done = 1'b0;
  logic       up_arready, dn_arvalid, up_awready, dn_awvalid, pad_pd;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  pad_sleep_gate u0 (
    .clk(clk), .rst_n(rst_n), .us_tick(us_tick), .sleep_en(sleep_en),
    .idle_limit(idle_limit), .wake_limit(wake_limit),
    .up_arvalid(up_arvalid), .up_arready(up_arready),
    .dn_arvalid(dn_arvalid), .dn_arready(dn_arready),
    .up_awvalid(up_awvalid), .up_awready(up_awready),
    .dn_awvalid(dn_awvalid), .dn_awready(dn_awready),
    .rd_done(rd_done), .wr_done(wr_done), .pad_pd(pad_pd)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic drive_edge();
    @(posedge clk); #1;
  endtask

  task automatic give_tick();
    drive_edge(); us_tick = 1'b1;
    drive_edge(); us_tick = 1'b0;
    @(negedge clk);
  endtask

  task automatic idle_cycles(input int n);
    repeat (n) drive_edge();
    @(negedge clk);
  endtask

  // wake through one channel; returns cycles from first low pad_pd to ready
  task automatic wake_and_measure(input bit use_aw, input int eff_w, input string ztag);
    int n;
    drive_edge();
    if (use_aw) begin up_awvalid = 1'b1; dn_awready = 1'b1; end
    else        begin up_arvalid = 1'b1; dn_arready = 1'b1; end
    @(negedge clk);
    chk("R6 blocked while asleep", int'(up_arready | up_awready | dn_arvalid | dn_awvalid), 0);
    n = 0;
    forever begin
      drive_edge(); @(negedge clk);
      n++;
      if (n == 1) chk("R7 pad wakes next cycle", int'(pad_pd), 0);
      if ((use_aw ? up_awready : up_arready) || n > 60) break;
      chk("R6 blocked while waking", int'(dn_arvalid | dn_awvalid), 0);
    end
    chk({"R8 wake window ", ztag}, n - 1, eff_w);
    drive_edge();
    up_arvalid = 1'b0; up_awvalid = 1'b0;
    dn_arready = 1'b0; dn_awready = 1'b0;
  endtask

  initial begin
    int il_set[5] = '{0, 1, 2, 3, 7};
    int wl_set[5] = '{0, 1, 2, 5, 31};
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    chk("R1 reset pad", int'(pad_pd), 0);
    chk("R1 reset ar pass", int'(dn_arvalid | up_arready), 0);
    drive_edge(); up_arvalid = 1'b1;
    @(negedge clk);
    chk("R1 ar valid passes after reset", int'(dn_arvalid), 1);
    drive_edge(); up_arvalid = 1'b0;
    idle_cycles(2);

    sleep_en = 1'b1;
    foreach (il_set[i]) begin
      foreach (wl_set[j]) begin
        int eff_i, eff_w;
        string itag, wtag;
        eff_i = (il_set[i] == 0) ? 1 : il_set[i];
        eff_w = (wl_set[j] == 0) ? 1 : wl_set[j];
        itag  = (il_set[i] == 0) ? "R10" : "R3";
        wtag  = (wl_set[j] == 0) ? "R10" : "";
        drive_edge();
        idle_limit = 9'(il_set[i]);
        wake_limit = 5'(wl_set[j]);
        idle_cycles(2);

        for (int k = 1; k <= eff_i; k++) begin
          give_tick();
          chk({itag, " idle threshold"}, int'(pad_pd), int'(k == eff_i));
        end
        wake_and_measure(1'b0, eff_w, wtag);

        // R9: read outstanding blocks power-down
        for (int k = 0; k < eff_i + 2; k++) give_tick();
        chk("R9 outstanding holds awake", int'(pad_pd), 0);
        drive_edge(); rd_done = 1'b1;
        drive_edge(); rd_done = 1'b0;
        idle_cycles(2);

        // R4: request on the threshold tick
        for (int k = 1; k < eff_i; k++) give_tick();
        drive_edge(); us_tick = 1'b1; up_awvalid = 1'b1;
        @(negedge clk);
        chk("R2 aw valid passes", int'(dn_awvalid), 1);
        chk("R2 aw ready follows", int'(up_awready), 0);
        drive_edge(); us_tick = 1'b0; up_awvalid = 1'b0;
        @(negedge clk);
        chk("R4 request on threshold tick", int'(pad_pd), 0);
        idle_cycles(2);
        for (int k = 1; k <= eff_i; k++) begin
          give_tick();
          chk("R4 count restarts", int'(pad_pd), int'(k == eff_i));
        end
        wake_and_measure(1'b1, eff_w, wtag);
        drive_edge(); wr_done = 1'b1;
        drive_edge(); wr_done = 1'b0;
        idle_cycles(3);
      end
    end

    // R5: enable low
    drive_edge(); sleep_en = 1'b0; idle_limit = 9'd1;
    idle_cycles(2);
    for (int k = 0; k < 6; k++) begin
      give_tick();
      chk("R5 disabled never sleeps", int'(pad_pd), 0);
    end
    drive_edge(); up_arvalid = 1'b1; dn_arready = 1'b0;
    @(negedge clk);
    chk("R2 ar ready held by controller", int'(up_arready), 0);
    drive_edge(); dn_arready = 1'b1;
    @(negedge clk);
    chk("R2 ar ready follows", int'(up_arready), 1);
    drive_edge(); up_arvalid = 1'b0; dn_arready = 1'b0;
    drive_edge(); rd_done = 1'b1;
    drive_edge(); rd_done = 1'b0;
    idle_cycles(2);

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule